// File: doc/BRIEF.md
# SPI flash passthrough command tracker

This block follows one command at a time as it passes from an SPI host to a downstream serial flash. It runs on the host serial clock, and a high chip select resets it asynchronously. It receives the 8-bit opcode most-significant bit first on the host data line. It matches the opcode against a table of command descriptors, and it can veto the opcode through a 256-bit filter bitmap.

After the opcode, a phase machine steps through the phases the descriptor asks for: address, mode byte, dummy cycles and payload. At each step it reports whether the host side drives the data lines or releases them. It produces the output enable for the downstream data lines. For a vetoed opcode it holds a forced chip-select deassert until the host ends the transaction.

The read-pipeline mode of the matched descriptor is latched and presented for the data path. Opcode compare work starts one bit early, so the decision is ready on the final opcode bit.

Top module: `spi_pt_cmd_tracker`

## Requirements
- R1: While chip select is high, phase_o is Idle (0), dn_csb_force_o is 0, rd_pipe_mode_o is 0 and dn_oe_o is 0. Phase codes are: Idle 0, Filter 1, Address 2, ModeByte 3, HighZ 4, Wait 5, Driving 6.
- R2: Opcode bits are sampled on rising serial-clock edges, most significant first. The phase stays Idle through the 7th edge and leaves Idle only on the 8th edge after chip select falls.
- R3: If bit [opcode] of filter_map_i is set, the 8th edge moves to Filter, regardless of the table. dn_csb_force_o is then 1 until chip select rises, and the phase stays Filter until then.
- R4: Each 23-bit descriptor in cmd_table_i holds these fields: opcode [7:0], valid [8], address mode [10:9], mode-byte enable [11], dummy enable [12], dummy length minus one [15:13], payload enable [19:16], payload direction [20] (1 = host to device) and read pipe mode [22:21]. When several entries match, the lowest index wins. An opcode that matches no entry, or that matches an entry whose valid bit is clear, goes to Wait.
- R5: A valid, unfiltered opcode leaves Idle in this order of priority. It goes to Address if the address mode is nonzero. Otherwise it goes to HighZ if dummy is enabled. Otherwise it goes to Driving if the payload enable is nonzero and the direction is 1, and to Wait in every other case. Driving and Wait hold until chip select rises.
- R6: The address phase lasts 32 edges when the address mode is 2 and 24 edges for any other nonzero mode. It then goes to ModeByte if enabled, else to HighZ if dummy is enabled, else to Driving or Wait by the payload rule of R5.
- R7: ModeByte lasts 8 edges and then always goes to HighZ.
- R8: HighZ lasts (dummy length minus one)+1 edges, then goes to Driving if the payload direction is 1 and to Wait otherwise.
- R9: The tracker is active only while pt_mode_i is 1 and pt_block_i is 0. While inactive, the phase is held at Idle and dn_oe_o is 0.
- R10: host_drive_o is 1 in Idle, Address, ModeByte and Driving, and 0 in Filter, HighZ and Wait. dn_oe_o equals host_drive_o while the tracker is active and chip select is low, and is 0 otherwise.
- R11: rd_pipe_mode_o shows the pipe-mode field of the matched descriptor from the 8th edge on, is 0 for an unmatched opcode, and is cleared by chip select.
- R12: phase_o always holds one of the seven phase codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck_i | input | 1 | Host serial clock |
| csb_i | input | 1 | Host chip select, active low; high resets the tracker |
| mosi_i | input | 1 | Host data line 0, sampled on rising sck |
| pt_mode_i | input | 1 | Passthrough mode selected |
| pt_block_i | input | 1 | Passthrough blocked |
| filter_map_i | input | 256 | Per-opcode veto bitmap |
| cmd_table_i | input | NUM_CMD*23 | Flattened descriptor table, entry i at bits [i*23 +: 23] |
| phase_o | output | 3 | Current phase code |
| host_drive_o | output | 1 | Host side drives the data lines in this phase |
| dn_oe_o | output | 1 | Output enable for the downstream data lines |
| dn_csb_force_o | output | 1 | Force downstream chip select deasserted |
| rd_pipe_mode_o | output | 2 | Latched read pipeline mode |

## Verification
A wrong phase shows on phase_o, host_drive_o and dn_oe_o on the edge right after the faulty decision. The tests sample each phase boundary one edge before and exactly at the edge where the change is expected, so an address, mode-byte or dummy count that is off by one edge is seen. A wrong descriptor choice shows as the wrong next phase or the wrong rd_pipe_mode_o. A table entry that shares an opcode but carries a different pipe mode separates lowest-index priority from any other choice. A filter decision that slips is visible on dn_csb_force_o in the cycle after the 8th edge.

// File: rtl/spi_pt_pkg.sv
package spi_pt_pkg;
    localparam int OP_W       = 8;
    localparam int FILTER_W   = 1 << OP_W;
    localparam int ADDR3_BITS = 24;
    localparam int ADDR4_BITS = 32;
    localparam int MBYTE_BITS = 8;
    localparam int DUMMY_W    = 3;
    localparam int CNT_W      = $clog2(ADDR4_BITS);

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FILTER = 3'd1,
        PH_ADDR   = 3'd2,
        PH_MBYTE  = 3'd3,
        PH_HIZ    = 3'd4,
        PH_WAIT   = 3'd5,
        PH_DRIVE  = 3'd6
    } phase_e;

    typedef struct packed {
        logic [1:0]         pipe_mode;
        logic               dir_out;
        logic [3:0]         pay_en;
        logic [DUMMY_W-1:0] dummy_m1;
        logic               dummy_en;
        logic               mbyte_en;
        logic [1:0]         addr_mode;
    } info_t;

    typedef struct packed {
        info_t             info;
        logic              valid;
        logic [OP_W-1:0]   opcode;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);
endpackage

// File: rtl/spi_pt_opcode_rx.sv
module spi_pt_opcode_rx
    import spi_pt_pkg::*;
(
    input  logic            sck_i,
    input  logic            csb_i,
    input  logic            mosi_i,
    output logic            at7_o,
    output logic            at8_o,
    output logic [OP_W-2:0] op7_o,
    output logic [OP_W-1:0] op_full_o
);
    localparam int BC_W = $clog2(OP_W + 1);

    typedef struct packed {
        logic [BC_W-1:0] bitcnt;
        logic [OP_W-2:0] shift;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (rx_q.bitcnt != BC_W'(OP_W)) begin
            rx_d.bitcnt = rx_q.bitcnt + BC_W'(1);
            rx_d.shift  = {rx_q.shift[OP_W-3:0], mosi_i};
        end
    end

    always_ff @(posedge sck_i or posedge csb_i) begin
        if (csb_i) rx_q <= '0;
        else       rx_q <= rx_d;
    end

    assign at7_o     = (rx_q.bitcnt == BC_W'(OP_W - 2));
    assign at8_o     = (rx_q.bitcnt == BC_W'(OP_W - 1));
    assign op7_o     = {rx_q.shift[OP_W-3:0], mosi_i};
    assign op_full_o = {rx_q.shift, mosi_i};
endmodule

// File: rtl/spi_pt_cmd_match.sv
module spi_pt_cmd_match
    import spi_pt_pkg::*;
#(
    parameter int NUM_CMD = 8
) (
    input  logic                    sck_i,
    input  logic                    csb_i,
    input  logic                    at7_i,
    input  logic [OP_W-2:0]         op7_i,
    input  logic                    bit_i,
    input  logic [NUM_CMD*DESC_W-1:0] table_i,
    output logic                    sel_valid_o,
    output info_t                   sel_info_o
);
    desc_t              ent [NUM_CMD];
    logic [NUM_CMD-1:0] hit1_d, hit0_d, hit1_q, hit0_q, hits;

    for (genvar g = 0; g < NUM_CMD; g++) begin : g_ent
        assign ent[g]    = table_i[g*DESC_W +: DESC_W];
        assign hit1_d[g] = (ent[g].opcode == {op7_i, 1'b1});
        assign hit0_d[g] = (ent[g].opcode == {op7_i, 1'b0});
    end

    always_ff @(posedge sck_i or posedge csb_i) begin
        if (csb_i) begin
            hit1_q <= '0;
            hit0_q <= '0;
        end else if (at7_i) begin
            hit1_q <= hit1_d;
            hit0_q <= hit0_d;
        end
    end

    always_comb begin
        hits        = bit_i ? hit1_q : hit0_q;
        sel_valid_o = 1'b0;
        sel_info_o  = '0;
        for (int i = NUM_CMD - 1; i >= 0; i--) begin
            if (hits[i]) begin
                sel_valid_o = ent[i].valid;
                sel_info_o  = ent[i].info;
            end
        end
    end
endmodule

// File: rtl/spi_pt_phase_fsm.sv
module spi_pt_phase_fsm
    import spi_pt_pkg::*;
(
    input  logic                sck_i,
    input  logic                csb_i,
    input  logic                active_i,
    input  logic                at8_i,
    input  logic [OP_W-1:0]     op_full_i,
    input  logic [FILTER_W-1:0] filter_map_i,
    input  logic                sel_valid_i,
    input  info_t               sel_info_i,
    output phase_e              phase_o,
    output logic [1:0]          pipe_mode_o
);
    localparam logic [CNT_W-1:0] A4_LAST = CNT_W'(ADDR4_BITS - 1);
    localparam logic [CNT_W-1:0] A3_LAST = CNT_W'(ADDR3_BITS - 1);
    localparam logic [CNT_W-1:0] MB_LAST = CNT_W'(MBYTE_BITS - 1);

    typedef struct packed {
        phase_e           st;
        logic [CNT_W-1:0] cnt;
        info_t            info;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            PH_IDLE: begin
                if (at8_i) begin
                    fsm_d.info = sel_info_i;
                    if (filter_map_i[op_full_i]) begin
                        fsm_d.st = PH_FILTER;
                    end else if (!sel_valid_i) begin
                        fsm_d.st = PH_WAIT;
                    end else if (sel_info_i.addr_mode != 2'd0) begin
                        fsm_d.st  = PH_ADDR;
                        fsm_d.cnt = (sel_info_i.addr_mode == 2'd2) ? A4_LAST : A3_LAST;
                    end else if (sel_info_i.dummy_en) begin
                        fsm_d.st  = PH_HIZ;
                        fsm_d.cnt = CNT_W'(sel_info_i.dummy_m1);
                    end else if ((sel_info_i.pay_en != 4'd0) && sel_info_i.dir_out) begin
                        fsm_d.st = PH_DRIVE;
                    end else begin
                        fsm_d.st = PH_WAIT;
                    end
                end
            end
            PH_ADDR: begin
                if (fsm_q.cnt != '0) begin
                    fsm_d.cnt = fsm_q.cnt - CNT_W'(1);
                end else if (fsm_q.info.mbyte_en) begin
                    fsm_d.st  = PH_MBYTE;
                    fsm_d.cnt = MB_LAST;
                end else if (fsm_q.info.dummy_en) begin
                    fsm_d.st  = PH_HIZ;
                    fsm_d.cnt = CNT_W'(fsm_q.info.dummy_m1);
                end else if ((fsm_q.info.pay_en != 4'd0) && fsm_q.info.dir_out) begin
                    fsm_d.st = PH_DRIVE;
                end else begin
                    fsm_d.st = PH_WAIT;
                end
            end
            PH_MBYTE: begin
                if (fsm_q.cnt != '0) begin
                    fsm_d.cnt = fsm_q.cnt - CNT_W'(1);
                end else begin
                    fsm_d.st  = PH_HIZ;
                    fsm_d.cnt = CNT_W'(fsm_q.info.dummy_m1);
                end
            end
            PH_HIZ: begin
                if (fsm_q.cnt != '0) begin
                    fsm_d.cnt = fsm_q.cnt - CNT_W'(1);
                end else begin
                    fsm_d.st = fsm_q.info.dir_out ? PH_DRIVE : PH_WAIT;
                end
            end
            PH_FILTER, PH_WAIT, PH_DRIVE: fsm_d.st = fsm_q.st;
            default: begin
                fsm_d.st  = PH_IDLE;
                fsm_d.cnt = '0;
            end
        endcase
        if (!active_i) begin
            fsm_d.st  = PH_IDLE;
            fsm_d.cnt = '0;
        end
    end

    always_ff @(posedge sck_i or posedge csb_i) begin
        if (csb_i) fsm_q <= '{st: PH_IDLE, cnt: '0, info: '0};
        else       fsm_q <= fsm_d;
    end

    assign phase_o     = fsm_q.st;
    assign pipe_mode_o = fsm_q.info.pipe_mode;
endmodule

// File: rtl/spi_pt_cmd_tracker.sv
module spi_pt_cmd_tracker
    import spi_pt_pkg::*;
#(
    parameter int NUM_CMD = 8
) (
    input  logic                      sck_i,
    input  logic                      csb_i,
    input  logic                      mosi_i,
    input  logic                      pt_mode_i,
    input  logic                      pt_block_i,
    input  logic [FILTER_W-1:0]       filter_map_i,
    input  logic [NUM_CMD*DESC_W-1:0] cmd_table_i,
    output logic [2:0]                phase_o,
    output logic                      host_drive_o,
    output logic                      dn_oe_o,
    output logic                      dn_csb_force_o,
    output logic [1:0]                rd_pipe_mode_o
);
    logic            active;
    logic            at7, at8;
    logic [OP_W-2:0] op7;
    logic [OP_W-1:0] op_full;
    logic            sel_valid;
    info_t           sel_info;
    phase_e          phase;

    assign active = pt_mode_i & ~pt_block_i;

    spi_pt_opcode_rx u_rx (
        .sck_i     (sck_i),
        .csb_i     (csb_i),
        .mosi_i    (mosi_i),
        .at7_o     (at7),
        .at8_o     (at8),
        .op7_o     (op7),
        .op_full_o (op_full)
    );

    spi_pt_cmd_match #(.NUM_CMD(NUM_CMD)) u_match (
        .sck_i       (sck_i),
        .csb_i       (csb_i),
        .at7_i       (at7),
        .op7_i       (op7),
        .bit_i       (mosi_i),
        .table_i     (cmd_table_i),
        .sel_valid_o (sel_valid),
        .sel_info_o  (sel_info)
    );

    spi_pt_phase_fsm u_fsm (
        .sck_i        (sck_i),
        .csb_i        (csb_i),
        .active_i     (active),
        .at8_i        (at8),
        .op_full_i    (op_full),
        .filter_map_i (filter_map_i),
        .sel_valid_i  (sel_valid),
        .sel_info_i   (sel_info),
        .phase_o      (phase),
        .pipe_mode_o  (rd_pipe_mode_o)
    );

    always_comb begin
        case (phase)
            PH_IDLE, PH_ADDR, PH_MBYTE, PH_DRIVE: host_drive_o = 1'b1;
            default:                              host_drive_o = 1'b0;
        endcase
    end

    assign phase_o        = phase;
    assign dn_oe_o        = host_drive_o & active & ~csb_i;
    assign dn_csb_force_o = (phase == PH_FILTER);
endmodule

// File: rtl/spi_pt_cmd_tracker_chk.sv
module spi_pt_cmd_tracker_chk (
    input logic       sck_i,
    input logic       csb_i,
    input logic       active_i,
    input logic       last_bit_i,
    input logic [2:0] phase_i
);
    AST_PHASE_LEGAL: assert property (@(posedge sck_i) disable iff (csb_i)
        phase_i <= 3'd6); // R12

    AST_EXIT_IDLE_ON_8TH: assert property (@(posedge sck_i) disable iff (csb_i)
        (phase_i != 3'd0 && $past(phase_i) == 3'd0) |-> $past(last_bit_i)); // R2

    AST_FILTER_HOLDS: assert property (@(posedge sck_i) disable iff (csb_i)
        ($past(phase_i) == 3'd1 && $past(active_i)) |-> phase_i == 3'd1); // R3

    AST_DRIVE_HOLDS: assert property (@(posedge sck_i) disable iff (csb_i)
        ($past(phase_i) == 3'd6 && $past(active_i)) |-> phase_i == 3'd6); // R5

    AST_MBYTE_TO_HIZ: assert property (@(posedge sck_i) disable iff (csb_i)
        ($past(phase_i) == 3'd3 && phase_i != 3'd3) |-> phase_i == 3'd4); // R7

    AST_INACTIVE_IDLE: assert property (@(posedge sck_i) disable iff (csb_i)
        !active_i |=> phase_i == 3'd0); // R9
endmodule

bind spi_pt_cmd_tracker spi_pt_cmd_tracker_chk chk_i (
    .sck_i      (sck_i),
    .csb_i      (csb_i),
    .active_i   (active),
    .last_bit_i (at8),
    .phase_i    (phase_o)
);

// File: tb/spi_pt_cmd_tracker_tb_top.sv
module spi_pt_cmd_tracker_tb_top;
    localparam int NC = 8;
    localparam int DW = 23;

    logic           clk = 1'b0;
    logic           csb = 1'b1;
    logic           mosi = 1'b0;
    logic           pt_mode = 1'b1;
    logic           pt_block = 1'b0;
    logic [255:0]   fmap = '0;
    logic [NC*DW-1:0] tbl = '0;
    logic [2:0]     phase;
    logic           drive, oe, force_cs;
    logic [1:0]     pipe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_pt_cmd_tracker #(.NUM_CMD(NC)) dut_i (
        .sck_i          (clk),
        .csb_i          (csb),
        .mosi_i         (mosi),
        .pt_mode_i      (pt_mode),
        .pt_block_i     (pt_block),
        .filter_map_i   (fmap),
        .cmd_table_i    (tbl),
        .phase_o        (phase),
        .host_drive_o   (drive),
        .dn_oe_o        (oe),
        .dn_csb_force_o (force_cs),
        .rd_pipe_mode_o (pipe)
    );

    function automatic logic [DW-1:0] mk(input logic [7:0] op, input logic v,
                                         input logic [1:0] am, input logic mb,
                                         input logic de, input logic [2:0] dm1,
                                         input logic [3:0] pe, input logic dir,
                                         input logic [1:0] pm);
        return {pm, dir, pe, dm1, de, mb, am, v, op};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_phase(input string req, input int exp);
        chk(req, phase, exp);
        chk("R12 legal phase", (phase <= 6) ? 1 : 0, 1);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic send_op(input logic [7:0] op);
        @(negedge clk);
        csb = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            mosi = op[i];
            if (i == 0) chk_phase("R2 idle through 7th bit", 0);
            @(posedge clk);
            @(negedge clk);
        end
        mosi = 1'b0;
    endtask

    task automatic end_cmd();
        csb = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_phase("R1 reset phase", 0);
        chk("R1 reset force", force_cs, 0);
        chk("R1 reset pipe", pipe, 0);
        chk("R1 reset oe", oe, 0);
    endtask

    task automatic t_read3();
        send_op(8'h03);
        chk_phase("R5 addr first", 2);
        chk("R10 drive in addr", drive, 1);
        chk("R10 oe in addr", oe, 1);
        chk("R4 lowest index pipe", pipe, 0);
        tick(23);
        chk_phase("R6 3B addr still", 2);
        tick(1);
        chk_phase("R6 3B addr to wait", 5);
        chk("R10 drive in wait", drive, 0);
        chk("R10 oe in wait", oe, 0);
        end_cmd();
    endtask

    task automatic t_fast();
        send_op(8'h0B);
        chk("R11 pipe full", pipe, 2);
        tick(24);
        chk_phase("R6 addr to hiz", 4);
        chk("R10 drive in hiz", drive, 0);
        tick(7);
        chk_phase("R8 hiz still", 4);
        tick(1);
        chk_phase("R8 hiz to wait", 5);
        end_cmd();
        chk("R11 pipe cleared", pipe, 0);
    endtask

    task automatic t_pp4();
        send_op(8'h02);
        chk_phase("R6 4B addr", 2);
        tick(31);
        chk_phase("R6 4B addr still", 2);
        tick(1);
        chk_phase("R6 4B addr to drive", 6);
        chk("R10 drive in driving", drive, 1);
        chk("R10 oe in driving", oe, 1);
        tick(5);
        chk_phase("R5 driving holds", 6);
        end_cmd();
    endtask

    task automatic t_mbyte();
        send_op(8'hEB);
        chk("R11 pipe half", pipe, 1);
        tick(24);
        chk_phase("R6 addr to mbyte", 3);
        chk("R10 drive in mbyte", drive, 1);
        tick(7);
        chk_phase("R7 mbyte still", 3);
        tick(1);
        chk_phase("R7 mbyte to hiz", 4);
        tick(3);
        chk_phase("R8 hiz 4 still", 4);
        tick(1);
        chk_phase("R8 hiz to wait", 5);
        end_cmd();
    endtask

    task automatic t_direct();
        send_op(8'h5A);
        chk_phase("R5 idle to hiz", 4);
        tick(1);
        chk_phase("R8 hiz 2 still", 4);
        tick(1);
        chk_phase("R8 hiz to drive", 6);
        end_cmd();
        send_op(8'h06);
        chk_phase("R5 idle to drive", 6);
        end_cmd();
    endtask

    task automatic t_nomatch();
        send_op(8'h38);
        chk_phase("R4 invalid entry wait", 5);
        end_cmd();
        send_op(8'h0A);
        chk_phase("R4 unmatched wait", 5);
        chk("R11 unmatched pipe", pipe, 0);
        end_cmd();
        send_op(8'hFF);
        chk_phase("R4 unmatched FF wait", 5);
        end_cmd();
    endtask

    task automatic t_filter();
        fmap[8'h02] = 1'b1;
        fmap[8'hC7] = 1'b1;
        send_op(8'h02);
        chk_phase("R3 filter over table", 1);
        chk("R3 force set", force_cs, 1);
        chk("R10 drive in filter", drive, 0);
        tick(40);
        chk_phase("R3 filter holds", 1);
        chk("R3 force holds", force_cs, 1);
        end_cmd();
        chk("R3 force released", force_cs, 0);
        chk_phase("R1 idle after filter", 0);
        send_op(8'hC7);
        chk_phase("R3 filter unmatched op", 1);
        end_cmd();
        fmap = '0;
        send_op(8'h02);
        chk_phase("R3 cleared map no filter", 2);
        end_cmd();
    endtask

    task automatic t_inactive();
        pt_mode = 1'b0;
        send_op(8'h03);
        chk_phase("R9 mode off idle", 0);
        chk("R9 mode off oe", oe, 0);
        tick(30);
        chk_phase("R9 mode off stays idle", 0);
        end_cmd();
        pt_mode = 1'b1;
        pt_block = 1'b1;
        send_op(8'h06);
        chk_phase("R9 blocked idle", 0);
        chk("R10 drive idle inactive", drive, 1);
        chk("R9 blocked oe", oe, 0);
        end_cmd();
        pt_block = 1'b0;
        send_op(8'h06);
        chk_phase("R9 active again", 6);
        end_cmd();
    endtask

    initial begin
        tbl[0*DW +: DW] = mk(8'h03, 1, 2'd1, 0, 0, 3'd0, 4'h1, 0, 2'd0);
        tbl[1*DW +: DW] = mk(8'h0B, 1, 2'd1, 0, 1, 3'd7, 4'h1, 0, 2'd2);
        tbl[2*DW +: DW] = mk(8'h02, 1, 2'd2, 0, 0, 3'd0, 4'h1, 1, 2'd0);
        tbl[3*DW +: DW] = mk(8'hEB, 1, 2'd1, 1, 1, 3'd3, 4'hF, 0, 2'd1);
        tbl[4*DW +: DW] = mk(8'h5A, 1, 2'd0, 0, 1, 3'd1, 4'h1, 1, 2'd0);
        tbl[5*DW +: DW] = mk(8'h06, 1, 2'd0, 0, 0, 3'd0, 4'h1, 1, 2'd0);
        tbl[6*DW +: DW] = mk(8'h38, 0, 2'd0, 0, 0, 3'd0, 4'h1, 1, 2'd0);
        tbl[7*DW +: DW] = mk(8'h03, 1, 2'd0, 0, 0, 3'd0, 4'h1, 1, 2'd3);
        tick(3);
        t_reset();
        t_read3();
        t_fast();
        t_pp4();
        t_mbyte();
        t_direct();
        t_nomatch();
        t_filter();
        t_inactive();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule